// File: doc/BRIEF.md
# Backup Mode Entry Sequencer

This block runs on the slow clock and carries the chip from normal operation into a low-power backup state once software asks for the core regulator to be turned off. The request comes from another clock domain. It first passes through a two-stage synchroniser. The sequencer then walks a fixed order, one slow clock cycle per step:

1. It raises the system reset.
2. It stops the processor and peripherals.
3. It removes the core regulator enable and pulls the active-low shutdown pin down.

A configuration input states whether the internal regulator is in use. When that input is low, the core is supplied externally and the regulator enable stays low at all times. A request made in that case still produces reset, stop and shutdown.

Once started, the sequence cannot be withdrawn. Only a power-on reset brings the block back to idle. A 2-bit state output lets test equipment observe how far the sequence has progressed.

Top module: `bkp_entry_seq`

## Requirements
- R1: While `rst` is high and after it is released with no request, `state_o` is 0, `sys_rst_o` is 0, `core_stop_o` is 0, `shdn_n_o` is 1 and `reg_en_o` equals `reg_on_i`.
- R2: The request passes through two synchroniser stages. If `off_req_i` is first sampled high at rising edge k, `sys_rst_o` stays 0 after edges k and k+1 and becomes 1 after edge k+2.
- R3: Once `sys_rst_o` is 1, it stays 1 until `rst` is applied.
- R4: `core_stop_o` becomes 1 exactly one slow clock cycle after `sys_rst_o` rises, and then remains 1.
- R5: One cycle after `core_stop_o` rises, `reg_en_o` goes to 0 and `shdn_n_o` goes to 0.
- R6: While `reg_on_i` is 0, `reg_en_o` is 0 in every state. A change of `reg_on_i` before the backup state shows on `reg_en_o` in the same cycle.
- R7: A request made with `reg_on_i` at 0 still produces the reset, stop and shutdown timing of R2, R4 and R5. `reg_en_o` makes no transition during it.
- R8: Once the backup state is reached, neither `off_req_i` nor `reg_on_i` has any effect. All outputs hold: `reg_en_o`=0, `shdn_n_o`=0, `sys_rst_o`=1, `core_stop_o`=1. Only `rst` returns the block to idle.
- R9: `state_o` encodes the step: 0 idle, 1 reset asserted, 2 core stopped, 3 backup. Its value moves only 0→1→2→3 and then holds at 3.
- R10: An `off_req_i` pulse that is high for a single slow clock cycle starts the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| off_req_i | input | 1 | Regulator-off command, asynchronous to clk |
| reg_on_i | input | 1 | 1 = internal core regulator in use, 0 = core supplied externally |
| sys_rst_o | output | 1 | System reset, active high |
| core_stop_o | output | 1 | Stops processor and peripherals, active high |
| reg_en_o | output | 1 | Core regulator enable |
| shdn_n_o | output | 1 | Shutdown pin level, low in backup |
| state_o | output | 2 | Sequencer step (0 idle, 1 reset, 2 stop, 3 backup) |

## Verification
A wrong state register shows at the ports at once: every output is decoded from the current step. A step that is skipped or repeated moves the rise of `core_stop_o` or the fall of `shdn_n_o` by a cycle relative to `sys_rst_o`. A synchroniser of the wrong depth moves the rise of `sys_rst_o` away from the third edge after the request. A backup state that can be left shows up in the cycle after `off_req_i` or `reg_on_i` is toggled there. The bench therefore samples every output on every cycle, both through the sequence and after it.

// File: rtl/bkp_pkg.sv
package bkp_pkg;

    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 2'd0,
        ST_RESET  = 2'd1,
        ST_STOP   = 2'd2,
        ST_BACKUP = 2'd3
    } bkp_state_e;

    typedef struct packed {
        logic sys_rst;
        logic core_stop;
        logic reg_en;
        logic shdn_n;
    } bkp_outs_t;

    function automatic bkp_state_e bkp_next(input bkp_state_e cur, input logic trig);
        case (cur)
            ST_IDLE:  return trig ? ST_RESET : ST_IDLE;
            ST_RESET: return ST_STOP;
            default:  return ST_BACKUP;
        endcase
    endfunction

    function automatic bkp_outs_t bkp_decode(input bkp_state_e cur, input logic reg_on);
        bkp_outs_t o;
        o.sys_rst   = (cur != ST_IDLE);
        o.core_stop = (cur == ST_STOP) || (cur == ST_BACKUP);
        o.reg_en    = reg_on && (cur != ST_BACKUP);
        o.shdn_n    = (cur != ST_BACKUP);
        return o;
    endfunction

endpackage

// File: rtl/bkp_sync.sv
module bkp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bkp_fsm.sv
module bkp_fsm
    import bkp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trig_i,
    output bkp_state_e state_o
);
    bkp_state_e cur;

    always_ff @(posedge clk) begin
        if (rst) cur <= ST_IDLE;
        else     cur <= bkp_next(cur, trig_i);
    end

    assign state_o = cur;
endmodule

// File: rtl/bkp_entry_seq.sv
module bkp_entry_seq
    import bkp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               off_req_i,
    input  logic               reg_on_i,
    output logic               sys_rst_o,
    output logic               core_stop_o,
    output logic               reg_en_o,
    output logic               shdn_n_o,
    output logic [STATE_W-1:0] state_o
);
    logic       req_sync;
    bkp_state_e cur;
    bkp_outs_t  outs;

    bkp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (off_req_i),
        .q_o (req_sync)
    );

    bkp_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .trig_i  (req_sync),
        .state_o (cur)
    );

    always_comb outs = bkp_decode(cur, reg_on_i);

    assign sys_rst_o   = outs.sys_rst;
    assign core_stop_o = outs.core_stop;
    assign reg_en_o    = outs.reg_en;
    assign shdn_n_o    = outs.shdn_n;
    assign state_o     = cur;
endmodule

// File: rtl/bkp_entry_seq_chk.sv
module bkp_entry_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_on_i,
    input logic       sys_rst_o,
    input logic       core_stop_o,
    input logic       reg_en_o,
    input logic       shdn_n_o,
    input logic [1:0] state_o
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (state_o == 2'd0));

    // R3
    sysrst_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_o |=> sys_rst_o);

    // R4
    stop_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(core_stop_o) |-> $past(sys_rst_o) && !$past(core_stop_o));

    // R5
    regoff_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(shdn_n_o) |-> $past(core_stop_o));

    // R5
    shdn_implies_regoff_chk: assert property (@(posedge clk) disable iff (rst)
        !shdn_n_o |-> !reg_en_o);

    // R6
    ext_supply_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_on_i |-> !reg_en_o);

    // R8
    backup_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd3) |=> (state_o == 2'd3) && !shdn_n_o && core_stop_o);

    // R9
    step_order_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd1) |=> (state_o == 2'd2));

    // R9
    step_order2_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd2) |=> (state_o == 2'd3));
endmodule

bind bkp_entry_seq bkp_entry_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_on_i    (reg_on_i),
    .sys_rst_o   (sys_rst_o),
    .core_stop_o (core_stop_o),
    .reg_en_o    (reg_en_o),
    .shdn_n_o    (shdn_n_o),
    .state_o     (state_o)
);

// File: tb/tb_bkp_entry_seq.sv
`timescale 1ns/1ps
module tb_bkp_entry_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       off_req_i = 1'b0;
    logic       reg_on_i = 1'b1;
    logic       sys_rst_o, core_stop_o, reg_en_o, shdn_n_o;
    logic [1:0] state_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bkp_entry_seq dut (
        .clk         (clk),
        .rst         (rst),
        .off_req_i   (off_req_i),
        .reg_on_i    (reg_on_i),
        .sys_rst_o   (sys_rst_o),
        .core_stop_o (core_stop_o),
        .reg_en_o    (reg_en_o),
        .shdn_n_o    (shdn_n_o),
        .state_o     (state_o)
    );

    // expected port vector {state, sys_rst, core_stop, reg_en, shdn_n} from step and config
    function automatic logic [5:0] exp_vec(input int step, input logic cfg);
        logic [1:0] s = step[1:0];
        return {s, (step != 0), (step >= 2), (cfg && step != 3), (step != 3)};
    endfunction

    task automatic check(input int step, input logic cfg, input string req);
        logic [5:0] act = {state_o, sys_rst_o, core_stop_o, reg_en_o, shdn_n_o};
        logic [5:0] exp = exp_vec(step, cfg);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (state,rst,stop,en,shdn_n)", req, act, exp);
        end
    endtask

    // advance one posedge, then sample at the following negedge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        off_req_i = 1'b0;
        tick();
        check(0, reg_on_i, "R1 during reset");
        tick();
        rst = 1'b0;
        tick();
        check(0, reg_on_i, "R1 after reset");
    endtask

    // run one full sequence: pulse width, config, and random behaviour in backup
    task automatic run_seq(input int pulse, input logic cfg, input int idle);
        for (int i = 0; i < idle; i++) begin
            reg_on_i = 1'($urandom);
            tick();
            check(0, reg_on_i, "R6 idle follows config");
        end
        reg_on_i = cfg;
        off_req_i = 1'b1;
        tick();                                  // edge k
        if (pulse == 1) off_req_i = 1'b0;
        check(0, cfg, "R2 no effect after edge k");
        tick();                                  // edge k+1
        check(0, cfg, "R2 no effect after edge k+1");
        tick();                                  // edge k+2
        check(1, cfg, cfg ? "R2 reset on third edge" : "R7 reset on third edge");
        tick();
        check(2, cfg, cfg ? "R4 stop one cycle later" : "R7 stop one cycle later");
        tick();
        check(3, cfg, cfg ? "R5 regulator off and shutdown" : "R7 shutdown");
        for (int i = 0; i < 6; i++) begin
            off_req_i = 1'($urandom);
            reg_on_i  = 1'($urandom);
            tick();
            check(3, reg_on_i, "R8 backup held");
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        reg_on_i = 1'b1;
        do_reset();
        check(0, 1'b1, "R9 idle code");
        run_seq(5, 1'b1, 3);        // long level request
        do_reset();
        run_seq(1, 1'b1, 2);        // R10 single-cycle pulse
        do_reset();
        run_seq(1, 1'b0, 1);        // R7 external supply
        do_reset();
        for (int it = 0; it < 20; it++) begin
            run_seq(($urandom % 2) ? 1 : 3, 1'($urandom), 1 + ($urandom % 5));
            do_reset();
        end
        // R6 config toggles mid-sequence before backup
        reg_on_i = 1'b1;
        off_req_i = 1'b1;
        tick();
        off_req_i = 1'b0;
        tick();
        tick();
        reg_on_i = 1'b0;
        #0.1;
        check(1, 1'b0, "R6 config drop during reset step");
        reg_on_i = 1'b1;
        tick();
        check(2, 1'b1, "R6 config during stop step");
        tick();
        check(3, 1'b1, "R8 backup reached");
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule